// File: doc/BRIEF.md
# Transmit Pause Request Sequencer

This block sits beside the transmit engine of a full-duplex Ethernet MAC and turns a software request into exactly one outgoing pause control frame. When software raises its pause request bit and the MAC runs in full duplex, the block raises a graceful-stop request. The transmit engine then finishes the data frame it is already sending, and no new data frames start. Once the engine reports that it is idle, the block raises a one-cycle stop-complete interrupt. In the following cycles it emits the pause frame, one byte per transfer, on a valid/ready stream.

The frame has the 60-byte minimum length before CRC. It holds the reserved multicast destination, the station address as source, the MAC control type, the pause opcode and the 16-bit pause duration, and the rest is zero padding. After the last byte has been accepted, the block waits for the transmit engine to report that the frame has left. It then drops the graceful stop and, in the same cycle, pulses a clear for the software request bit. The station address and the duration are captured when the request is accepted. Preamble, CRC and collision handling belong to the transmit engine.

Top module: `pause_tx_seq`

## Requirements
- R1: After reset, gstop_req, stop_done_irq, fr_valid, fr_last and req_clear are all low.
- R2: With full_duplex high, sw_pause_req sampled high at a rising edge while idle sets gstop_req high from that edge on.
- R3: While full_duplex is low, sw_pause_req has no effect: gstop_req and req_clear stay low. The request stays pending, and it is honoured as soon as full_duplex goes high.
- R4: While gstop_req is high and before the frame, stop_done_irq stays low as long as tx_idle is low. stop_done_irq goes high for exactly one cycle in the cycle after tx_idle is sampled high.
- R5: fr_valid is never high before the stop-complete pulse. The first byte is offered in the cycle right after stop_done_irq.
- R6: Bytes 0 to 17 are, in order: 01 80 C2 00 00 01, then station_addr most significant byte first (bytes 6 to 11), then 88 08 (bytes 12 and 13), then 00 01 (bytes 14 and 15), then pause_quanta high byte then low byte (bytes 16 and 17).
- R7: Bytes 18 to 59 are 00. The frame is exactly 60 bytes, and fr_last is high on byte 59 only.
- R8: A byte is transferred when fr_valid and fr_ready are both high at a rising edge. While fr_valid is high and fr_ready is low, fr_valid stays high and fr_data and fr_last do not change.
- R9: After the last byte, gstop_req stays high and req_clear stays low until tx_frame_done is sampled high. In the next cycle req_clear is high for one cycle and gstop_req is already low.
- R10: Dropping sw_pause_req after it has been accepted does not abort or shorten the sequence.
- R11: station_addr and pause_quanta are captured at the edge where the request is accepted. Later changes to them do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_pause_req | input | 1 | Software pause request bit (level) |
| full_duplex | input | 1 | MAC configured for full duplex |
| station_addr | input | 48 | Station MAC address, used as source |
| pause_quanta | input | 16 | Pause duration field |
| tx_idle | input | 1 | Transmit engine has no data frame in flight |
| tx_frame_done | input | 1 | Transmit engine finished sending the pause frame |
| gstop_req | output | 1 | Graceful-stop request to the data path |
| stop_done_irq | output | 1 | One-cycle stop-complete interrupt |
| fr_valid | output | 1 | Frame byte valid |
| fr_data | output | 8 | Frame byte |
| fr_last | output | 1 | Marks the final byte of the frame |
| fr_ready | input | 1 | Transmit engine accepts the byte |
| req_clear | output | 1 | One-cycle clear of the software request bit |

## Verification
The hardest situation to reach from the ports is a request that arrives while the MAC is not in full duplex. The sequence must stay dormant without clearing the request, and it must then run as soon as the mode changes. To get there, the stimulus holds the request for many cycles with full_duplex low, then keeps tx_idle low for several cycles so the drain phase is exercised. A second run changes the address and duration and drops the request in the middle of the frame, with ready always high. The first run applies a ready pattern that stalls every third cycle, so the hold rule is tested on header bytes and on padding bytes.

// File: rtl/pause_pkg.sv
package pause_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_STOPPED,
    ST_SEND,
    ST_WAIT_DONE,
    ST_RELEASE
  } seq_state_e;

  localparam logic [47:0] CTRL_DEST_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_ETHERTYPE = 16'h8808;
  localparam logic [15:0] CTRL_OP_PAUSE  = 16'h0001;
  localparam int          HDR_BYTES      = 18;

endpackage

// File: rtl/pause_seq_ctrl.sv
module pause_seq_ctrl
  import pause_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_pause_req,
  input  logic full_duplex,
  input  logic tx_idle,
  input  logic tx_frame_done,
  input  logic frame_sent,
  output logic load,
  output logic send_en,
  output logic gstop_req,
  output logic stop_done_irq,
  output logic req_clear
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_pause_req && full_duplex) begin
          state_d = ST_DRAIN;
          load    = 1'b1;
        end
      end
      ST_DRAIN:     if (tx_idle) state_d = ST_STOPPED;
      ST_STOPPED:   state_d = ST_SEND;
      ST_SEND:      if (frame_sent) state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: if (tx_frame_done) state_d = ST_RELEASE;
      ST_RELEASE:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign gstop_req     = (state_q == ST_DRAIN) || (state_q == ST_STOPPED) ||
                         (state_q == ST_SEND)  || (state_q == ST_WAIT_DONE);
  assign stop_done_irq = (state_q == ST_STOPPED);
  assign send_en       = (state_q == ST_SEND);
  assign req_clear     = (state_q == ST_RELEASE);

  // R3: without full duplex the sequencer does not leave idle
  p_no_start_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !full_duplex) |=> (state_q == ST_IDLE));

  // R4: stop-complete is a single-cycle pulse
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done_irq |=> !stop_done_irq);

  // R4: draining holds while the transmitter is busy
  p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && !tx_idle) |=> !stop_done_irq);

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pause_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        send_en,
  input  logic [47:0] station_addr,
  input  logic [15:0] pause_quanta,
  input  logic        fr_ready,
  output logic        fr_valid,
  output logic [7:0]  fr_data,
  output logic        fr_last,
  output logic        frame_sent
);

  localparam int IDX_W   = $clog2(MIN_LEN);
  localparam int HDR_W   = 8 * HDR_BYTES;

  logic [47:0]      addr_q;
  logic [15:0]      quanta_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [HDR_W-1:0] hdr_w;
  logic [7:0]       byte_c;

  assign idx_en = load || (send_en && fr_ready);

  always_comb begin
    idx_d = idx_q;
    if (load)                       idx_d = '0;
    else if (send_en && fr_ready)   idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      quanta_q <= '0;
    end else if (load) begin
      addr_q   <= station_addr;
      quanta_q <= pause_quanta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign hdr_w = {CTRL_DEST_ADDR, addr_q, CTRL_ETHERTYPE, CTRL_OP_PAUSE, quanta_q};

  always_comb begin
    byte_c = 8'h00;
    for (int b = 0; b < HDR_BYTES; b++) begin
      if (idx_q == IDX_W'(b)) byte_c = hdr_w[8*(HDR_BYTES-1-b) +: 8];
    end
  end

  assign fr_valid   = send_en;
  assign fr_data    = byte_c;
  assign fr_last    = send_en && (idx_q == IDX_W'(MIN_LEN-1));
  assign frame_sent = fr_last && fr_ready;

  // R8: an offered byte is held until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready) |=> (fr_valid && $stable(fr_data) && $stable(fr_last)));

  // R7: the end marker only accompanies a valid byte
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fr_last |-> fr_valid);

endmodule

// File: rtl/pause_tx_seq.sv
module pause_tx_seq
  import pause_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_pause_req,
  input  logic        full_duplex,
  input  logic [47:0] station_addr,
  input  logic [15:0] pause_quanta,
  input  logic        tx_idle,
  input  logic        tx_frame_done,
  output logic        gstop_req,
  output logic        stop_done_irq,
  output logic        fr_valid,
  output logic [7:0]  fr_data,
  output logic        fr_last,
  input  logic        fr_ready,
  output logic        req_clear
);

  logic load, send_en, frame_sent;

  pause_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_pause_req  (sw_pause_req),
    .full_duplex   (full_duplex),
    .tx_idle       (tx_idle),
    .tx_frame_done (tx_frame_done),
    .frame_sent    (frame_sent),
    .load          (load),
    .send_en       (send_en),
    .gstop_req     (gstop_req),
    .stop_done_irq (stop_done_irq),
    .req_clear     (req_clear)
  );

  pause_frame_gen #(.MIN_LEN(MIN_LEN)) u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .send_en      (send_en),
    .station_addr (station_addr),
    .pause_quanta (pause_quanta),
    .fr_ready     (fr_ready),
    .fr_valid     (fr_valid),
    .fr_data      (fr_data),
    .fr_last      (fr_last),
    .frame_sent   (frame_sent)
  );

  // R5: the first byte follows the stop-complete pulse
  p_send_after_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_valid) |-> $past(stop_done_irq));

  // R9: release drops the stop in the clear cycle
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_clear |-> (!gstop_req && $past(gstop_req)));

  // R2: stop is only raised with full duplex configured
  p_stop_needs_fd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gstop_req) |-> $past(full_duplex && sw_pause_req));

endmodule

// File: tb/pause_tx_seq_bench.sv
module pause_tx_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LEN  = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_req = 1'b0;
  logic        req_set = 1'b0;
  logic        req_drop = 1'b0;
  logic        full_duplex = 1'b0;
  logic [47:0] station_addr = 48'h0;
  logic [15:0] pause_quanta = 16'h0;
  logic        tx_idle = 1'b0;
  logic        tx_frame_done = 1'b0;
  logic        gstop_req, stop_done_irq, fr_valid, fr_last, req_clear;
  logic [7:0]  fr_data;
  logic        fr_ready = 1'b0;
  logic        stall_mode = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int rdy_cnt = 0;
  logic [8:0] exp_q[$];
  logic       hold_pend = 1'b0;
  logic [8:0] hold_val = '0;

  pause_tx_seq u_pause_tx_seq (
    .clk (clk), .rst_n (rst_n), .sw_pause_req (sw_req), .full_duplex (full_duplex),
    .station_addr (station_addr), .pause_quanta (pause_quanta), .tx_idle (tx_idle),
    .tx_frame_done (tx_frame_done), .gstop_req (gstop_req), .stop_done_irq (stop_done_irq),
    .fr_valid (fr_valid), .fr_data (fr_data), .fr_last (fr_last), .fr_ready (fr_ready),
    .req_clear (req_clear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // software request register, cleared by hardware
  always @(posedge clk) begin
    if (req_clear || req_drop) sw_req <= 1'b0;
    else if (req_set)          sw_req <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: push the expected frame
  task automatic push_frame(input logic [47:0] sa, input logic [15:0] q);
    logic [8*18-1:0] hdr;
    hdr = {48'h0180C2000001, sa, 16'h8808, 16'h0001, q};
    for (int i = 0; i < FRAME_LEN; i++) begin
      logic [7:0] b;
      b = (i < 18) ? hdr[8*(17-i) +: 8] : 8'h00;
      exp_q.push_back({(i == FRAME_LEN-1), b});
    end
  endtask

  // monitor: drive ready, then compare accepted bytes
  always @(negedge clk) begin
    if (rst_n) begin
      rdy_cnt++;
      fr_ready = stall_mode ? (rdy_cnt % 3 != 0) : 1'b1;
      if (hold_pend)  // R8
        chk(fr_valid && ({fr_last, fr_data} == hold_val), "R8 hold", {fr_valid, fr_last, fr_data}, {1'b1, hold_val});
      hold_pend = fr_valid && !fr_ready;
      hold_val  = {fr_last, fr_data};
      if (fr_valid && fr_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 extra byte", {fr_last, fr_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({fr_last, fr_data} == e, "R6/R7 frame byte", {fr_last, fr_data}, e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        chk(1'b0, "watchdog", cycles, 50000);
        finish_run();
      end
    end
  end

  task automatic run_tail();
    bit saw_clear;
    saw_clear = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin  // R9 wait for done
      @(negedge clk);
      if (!gstop_req || req_clear || fr_valid) saw_clear = 1'b1;
    end
    chk(!saw_clear, "R9 hold until done", saw_clear, 0);
    tx_frame_done = 1'b1;
    @(negedge clk);
    tx_frame_done = 1'b0;
    chk(req_clear && !gstop_req, "R9 clear pulse", {req_clear, gstop_req}, 2'b10);
    @(negedge clk);
    chk(!req_clear && !sw_req && !gstop_req, "R9 clear single", {req_clear, sw_req, gstop_req}, 0);
  endtask

  initial begin
    bit bad;
    repeat (3) @(negedge clk);
    chk(!gstop_req && !stop_done_irq && !fr_valid && !fr_last && !req_clear, "R1 reset",
        {gstop_req, stop_done_irq, fr_valid, fr_last, req_clear}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!gstop_req && !req_clear, "R1 after release", {gstop_req, req_clear}, 0);

    // run 1: request while half duplex, then enable
    station_addr = 48'hA1B2C3D4E5F6;
    pause_quanta = 16'h1234;
    stall_mode   = 1'b1;
    req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (gstop_req || req_clear || fr_valid) bad = 1'b1;
    end
    chk(!bad, "R3 ignored without full duplex", bad, 0);
    chk(sw_req, "R3 request pending", sw_req, 1);
    push_frame(48'hA1B2C3D4E5F6, 16'h1234);
    full_duplex = 1'b1;
    @(negedge clk);
    chk(gstop_req, "R2 stop raised", gstop_req, 1);
    bad = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (stop_done_irq || fr_valid || !gstop_req) bad = 1'b1;
    end
    chk(!bad, "R4 drain waits for idle", bad, 0);
    tx_idle = 1'b1;
    @(negedge clk);
    chk(stop_done_irq && !fr_valid, "R4/R5 irq before data", {stop_done_irq, fr_valid}, 2'b10);
    @(negedge clk);
    chk(!stop_done_irq && fr_valid, "R4/R5 first byte next", {stop_done_irq, fr_valid}, 2'b01);
    run_tail();

    // run 2: capture and mid-sequence request drop
    stall_mode = 1'b0;
    tx_idle = 1'b0;
    station_addr = 48'h0011223344FF;
    pause_quanta = 16'hFF00;
    push_frame(48'h0011223344FF, 16'hFF00);
    req_set = 1'b1;
    @(negedge clk);
    req_set = 1'b0;
    @(negedge clk);
    chk(gstop_req, "R2 stop raised again", gstop_req, 1);
    station_addr = 48'hDEADBEEF0000;  // R11
    pause_quanta = 16'h5555;
    tx_idle = 1'b1;
    repeat (10) @(negedge clk);
    req_drop = 1'b1;  // R10
    @(negedge clk);
    req_drop = 1'b0;
    chk(fr_valid && gstop_req, "R10 no abort", {fr_valid, gstop_req}, 2'b11);
    run_tail();
    chk(exp_q.size() == 0, "R11 frame complete", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(!gstop_req && !fr_valid, "R10 no restart", {gstop_req, fr_valid}, 0);
    finish_run();
  end

endmodule